// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Controller

This block sits on the system clock and runs the asynchronous chip-enable, output-enable and write-enable bus of an 8K x 8 parallel EEPROM. A host asks for one of three operations: a read, a single-byte write or a page write. The block accepts one request at a time. For a page write it fetches bytes from the host by index, and the host holds the whole page in its own storage. Each byte goes into the device's page latch with a write-enable-controlled strobe. After the last strobe the controller polls the device until its internal program cycle has ended.

Two polling methods are available and the host picks one per request. In data polling, the controller re-reads the last written address until the most significant data bit matches the value written. In toggle polling, it keeps reading until the next-to-top bit returns the same value on two reads in a row. A cycle counter bounds the polling. If the counter runs out, the request ends with an error and a timeout flag is set and stays set. Every bus delay is a count of clock cycles, computed from a clock-period parameter and a set of nanosecond parameters.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: After reset the bus is idle: `ee_ce_n`, `ee_oe_n` and `ee_we_n` are high, `ee_dout_en` is low, `req_ready` is high and `err_timeout` is low. Each request ends with `done` high for exactly one cycle, and `req_ready` is high again afterwards.
- R2: A request is rejected when it is a page write (`req_op`=2) whose offset `req_addr[5:0]` plus `req_last` exceeds 63, or when `req_op`=3. A rejected request sets `done` and `done_err` in the cycle after acceptance and never pulls `ee_ce_n` low. A page whose offset plus `req_last` is exactly 63 is accepted.
- R3: A byte write (`req_op`=1) stores `data_byte` at `req_addr`. A page write stores, for each i from 0 to `req_last`, the byte presented while `data_idx`=i at address {`req_addr[12:6]`, `req_addr[5:0]`+i}.
- R4: Each write-enable low pulse lasts at least 150 ns. `ee_addr` is stable for at least 20 ns before the strobe falls and does not change while the strobe is low. `ee_dout` is stable while the strobe is low and is still driven for one cycle after it rises.
- R5: `ee_oe_n` is high whenever `ee_we_n` is low and whenever `ee_dout_en` is high. `ee_ce_n` is low during every strobe.
- R6: Within one page, consecutive falling edges of the write strobe are at least 200 ns and at most 2000 ns apart.
- R7: In data-polling mode (`req_toggle`=0), `done` with `done_err`=0 comes only after a read of the last written address returns bit 7 equal to the written bit 7.
- R8: In toggle mode (`req_toggle`=1), `done` with `done_err`=0 comes only after two consecutive polling reads return the same bit 6.
- R9: If polling has not finished within `POLL_TIMEOUT_NS`, the request ends with `done_err`=1 and `err_timeout` goes high. `err_timeout` then stays high until reset, even through later successful requests.
- R10: A read (`req_op`=0) holds `ee_ce_n` and `ee_oe_n` low for the access time. It then returns the byte on `ee_din` through `rd_data`, valid while `done` is high, with `done_err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is high |
| req_ready | output | 1 | Controller idle and able to accept |
| req_op | input | 2 | 0 read, 1 byte write, 2 page write, 3 rejected |
| req_addr | input | 13 | Byte address (start address for a page) |
| req_last | input | 6 | Index of the last page byte (count minus one) |
| req_toggle | input | 1 | 1 selects toggle polling, 0 data polling |
| data_idx | output | 6 | Index of the write byte the host must present |
| data_byte | input | 8 | Host byte for `data_idx` |
| done | output | 1 | One-cycle end-of-request pulse |
| done_err | output | 1 | Request rejected or timed out (valid with `done`) |
| rd_data | output | 8 | Read result (valid with `done`) |
| err_timeout | output | 1 | Sticky polling-timeout flag |
| ee_addr | output | 13 | Device address bus |
| ee_dout | output | 8 | Data driven toward the device |
| ee_dout_en | output | 1 | Output enable of the data pads |
| ee_din | input | 8 | Data returned by the device |
| ee_ce_n | output | 1 | Device chip enable, active low |
| ee_oe_n | output | 1 | Device output enable, active low |
| ee_we_n | output | 1 | Device write strobe, active low |

## Verification
The hardest case to produce is a polling timeout. It needs a device whose program cycle outlasts the timeout, while the controller still behaves correctly around it. The bench includes a cycle-level device model with a program time set per request. It runs the timeout with a program time longer than the shortened bench timeout. After that expiry, a following successful request confirms that the flag stays set. Random page lengths and offsets are pushed against the 64-byte boundary and onto it exactly, to exercise both sides of the rejection rule.

// File: rtl/eeprom_ctrl_pkg.sv
package eeprom_ctrl_pkg;

  typedef enum logic [1:0] {
    OP_READ = 2'd0,
    OP_BYTE = 2'd1,
    OP_PAGE = 2'd2,
    OP_RSVD = 2'd3
  } ee_op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LOAD, ST_WSET, ST_WLOW, ST_WHOLD, ST_WGAP,
    ST_PRD, ST_PGAP, ST_RD, ST_RHOLD, ST_FIN
  } ee_state_e;

  // round a nanosecond figure up to whole clock cycles
  function automatic int unsigned cyc_of_ns(input int unsigned ns, input int unsigned period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int unsigned at_least(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // pad cycles so a byte loop reaches the minimum strobe spacing, never below one
  function automatic int unsigned gap_pad(input int unsigned need, input int unsigned used);
    return (need > used) ? (need - used) : 1;
  endfunction

  // a page fits when its first offset plus last index stays inside one page
  function automatic logic page_fits(input int unsigned offset, input int unsigned last,
                                     input int unsigned page_bytes);
    return (offset + last) < page_bytes;
  endfunction

endpackage

// File: rtl/ee_wait_timer.sv
module ee_wait_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (load)          cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/ee_poll_judge.sv
module ee_poll_judge #(
  parameter int unsigned TMO_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic active,
  input  logic sample,
  input  logic toggle_mode,
  input  logic rd_msb,
  input  logic rd_tb,
  input  logic target_msb,
  output logic complete,
  output logic expired
);
  localparam int unsigned TMO_W = $clog2(TMO_CYC + 1);

  logic [TMO_W-1:0] age;
  logic             have_prev;
  logic             prev_tb;
  logic             msb_match;
  logic             tb_steady;

  assign msb_match = (rd_msb == target_msb);
  assign tb_steady = have_prev && (rd_tb == prev_tb);
  assign complete  = sample && (toggle_mode ? tb_steady : msb_match);
  assign expired   = (age == TMO_W'(TMO_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age       <= '0;
      have_prev <= 1'b0;
      prev_tb   <= 1'b0;
    end else if (arm) begin
      age       <= '0;
      have_prev <= 1'b0;
      prev_tb   <= 1'b0;
    end else begin
      if (active && !expired) age <= age + 1'b1;
      if (sample) begin
        have_prev <= 1'b1;
        prev_tb   <= rd_tb;
      end
    end
  end

  // R9: the timeout can only mature while a poll is running
  assert_expire_in_poll_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> $past(active));

  // R8: toggle completion needs an earlier sample to compare against
  assert_toggle_two_reads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (complete && toggle_mode) |-> have_prev);
endmodule

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl
  import eeprom_ctrl_pkg::*;
#(
  parameter int unsigned CLK_NS          = 10,
  parameter int unsigned ADDR_W          = 13,
  parameter int unsigned DATA_W          = 8,
  parameter int unsigned PAGE_BYTES      = 64,
  parameter int unsigned T_AS_NS         = 20,
  parameter int unsigned T_AH_NS         = 150,
  parameter int unsigned T_WP_NS         = 150,
  parameter int unsigned T_DS_NS         = 50,
  parameter int unsigned T_DH_NS         = 10,
  parameter int unsigned T_OES_NS        = 20,
  parameter int unsigned T_OEH_NS        = 20,
  parameter int unsigned T_BLC_MIN_NS    = 200,
  parameter int unsigned T_BLC_MAX_NS    = 2000,
  parameter int unsigned T_ACC_NS        = 200,
  parameter int unsigned POLL_TIMEOUT_NS = 10_000_000
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [1:0]                    req_op,
  input  logic [ADDR_W-1:0]             req_addr,
  input  logic [$clog2(PAGE_BYTES)-1:0] req_last,
  input  logic                          req_toggle,
  output logic [$clog2(PAGE_BYTES)-1:0] data_idx,
  input  logic [DATA_W-1:0]             data_byte,
  output logic                          done,
  output logic                          done_err,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          err_timeout,
  output logic [ADDR_W-1:0]             ee_addr,
  output logic [DATA_W-1:0]             ee_dout,
  output logic                          ee_dout_en,
  input  logic [DATA_W-1:0]             ee_din,
  output logic                          ee_ce_n,
  output logic                          ee_oe_n,
  output logic                          ee_we_n
);
  localparam int unsigned OFS_W     = $clog2(PAGE_BYTES);
  localparam int unsigned N_SET     = at_least(at_least(cyc_of_ns(T_AS_NS, CLK_NS),
                                                        cyc_of_ns(T_OES_NS, CLK_NS)), 1);
  localparam int unsigned N_WLOW    = at_least(at_least(cyc_of_ns(T_WP_NS, CLK_NS),
                                                        cyc_of_ns(T_AH_NS, CLK_NS)),
                                               at_least(cyc_of_ns(T_DS_NS, CLK_NS), 1));
  localparam int unsigned N_WHOLD   = at_least(at_least(cyc_of_ns(T_DH_NS, CLK_NS),
                                                        cyc_of_ns(T_OEH_NS, CLK_NS)), 1);
  localparam int unsigned N_BLC_MIN = cyc_of_ns(T_BLC_MIN_NS, CLK_NS);
  localparam int unsigned N_BLC_MAX = T_BLC_MAX_NS / CLK_NS;
  localparam int unsigned N_GAP     = gap_pad(N_BLC_MIN, 1 + N_SET + N_WLOW + N_WHOLD);
  localparam int unsigned N_ACC     = at_least(cyc_of_ns(T_ACC_NS, CLK_NS), 1);
  localparam int unsigned N_RGAP    = N_SET;
  localparam int unsigned TMO_CYC   = cyc_of_ns(POLL_TIMEOUT_NS, CLK_NS);
  localparam int unsigned TW        = $clog2(N_SET + N_WLOW + N_WHOLD + N_GAP + N_ACC + 2);
  localparam int unsigned GW        = $clog2(N_BLC_MAX + 2);

  ee_state_e             state, nxt;
  logic [OFS_W-1:0]      byte_idx, last_idx;
  logic [ADDR_W-1:0]     base_addr, addr_q;
  logic [DATA_W-1:0]     dout_q, rd_q;
  logic                  toggle_q, resp_err, tmo_flag;
  logic                  tmr_load, tmr_zero;
  logic [TW-1:0]         tmr_val;
  logic                  accept, reject, last_byte, poll_active, poll_sample;
  logic                  poll_arm, poll_done, poll_expired;
  ee_op_e                op_in;

  function automatic logic [TW-1:0] dwell(input ee_state_e s);
    case (s)
      ST_WSET:  return TW'(N_SET - 1);
      ST_WLOW:  return TW'(N_WLOW - 1);
      ST_WHOLD: return TW'(N_WHOLD - 1);
      ST_WGAP:  return TW'(N_GAP - 1);
      ST_PRD,
      ST_RD:    return TW'(N_ACC - 1);
      ST_PGAP,
      ST_RHOLD: return TW'(N_RGAP - 1);
      default:  return '0;
    endcase
  endfunction

  assign op_in       = ee_op_e'(req_op);
  assign accept      = (state == ST_IDLE) && req_valid;
  assign reject      = (op_in == OP_RSVD) ||
                       ((op_in == OP_PAGE) &&
                        !page_fits(32'(req_addr[OFS_W-1:0]), 32'(req_last), PAGE_BYTES));
  assign last_byte   = (byte_idx == last_idx);
  assign poll_active = (state == ST_PRD) || (state == ST_PGAP);
  assign poll_sample = (state == ST_PRD) && tmr_zero;
  assign poll_arm    = (state == ST_WHOLD) && tmr_zero && last_byte;

  ee_wait_timer #(.CNT_W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .zero(tmr_zero)
  );

  ee_poll_judge #(.TMO_CYC(TMO_CYC)) u_poll (
    .clk(clk), .rst_n(rst_n), .arm(poll_arm), .active(poll_active),
    .sample(poll_sample), .toggle_mode(toggle_q),
    .rd_msb(ee_din[DATA_W-1]), .rd_tb(ee_din[DATA_W-2]),
    .target_msb(dout_q[DATA_W-1]),
    .complete(poll_done), .expired(poll_expired)
  );

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  if (req_valid) begin
                  if (reject)                nxt = ST_FIN;
                  else if (op_in == OP_READ) nxt = ST_RD;
                  else                       nxt = ST_LOAD;
                end
      ST_LOAD:  nxt = ST_WSET;
      ST_WSET:  if (tmr_zero) nxt = ST_WLOW;
      ST_WLOW:  if (tmr_zero) nxt = ST_WHOLD;
      ST_WHOLD: if (tmr_zero) nxt = last_byte ? ST_PRD : ST_WGAP;
      ST_WGAP:  if (tmr_zero) nxt = ST_LOAD;
      ST_PRD:   if (tmr_zero) nxt = (poll_done || poll_expired) ? ST_FIN : ST_PGAP;
      ST_PGAP:  if (tmr_zero) nxt = poll_expired ? ST_FIN : ST_PRD;
      ST_RD:    if (tmr_zero) nxt = ST_RHOLD;
      ST_RHOLD: if (tmr_zero) nxt = ST_FIN;
      ST_FIN:   nxt = ST_IDLE;
      default:  nxt = ST_IDLE;
    endcase
    tmr_load = (nxt != state);
    tmr_val  = dwell(nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      byte_idx  <= '0;
      last_idx  <= '0;
      base_addr <= '0;
      addr_q    <= '0;
      dout_q    <= '0;
      rd_q      <= '0;
      toggle_q  <= 1'b0;
      resp_err  <= 1'b0;
      tmo_flag  <= 1'b0;
    end else begin
      state <= nxt;
      if (accept) begin
        base_addr <= req_addr;
        addr_q    <= req_addr;
        last_idx  <= (op_in == OP_PAGE) ? req_last : '0;
        byte_idx  <= '0;
        toggle_q  <= req_toggle;
        resp_err  <= reject;
      end
      if (state == ST_LOAD) begin
        addr_q <= {base_addr[ADDR_W-1:OFS_W], base_addr[OFS_W-1:0] + byte_idx};
        dout_q <= data_byte;
      end
      if ((state == ST_WHOLD) && tmr_zero && !last_byte) byte_idx <= byte_idx + 1'b1;
      if (((state == ST_PRD) && tmr_zero && !poll_done && poll_expired) ||
          ((state == ST_PGAP) && tmr_zero && poll_expired)) begin
        resp_err <= 1'b1;
        tmo_flag <= 1'b1;
      end
      if ((state == ST_RD) && tmr_zero) rd_q <= ee_din;
    end
  end

  assign req_ready   = (state == ST_IDLE);
  assign data_idx    = byte_idx;
  assign done        = (state == ST_FIN);
  assign done_err    = resp_err;
  assign rd_data     = rd_q;
  assign err_timeout = tmo_flag;
  assign ee_addr     = addr_q;
  assign ee_dout     = dout_q;
  assign ee_dout_en  = (state == ST_WSET) || (state == ST_WLOW) || (state == ST_WHOLD);
  assign ee_ce_n     = (state == ST_IDLE) || (state == ST_FIN);
  assign ee_oe_n     = !((state == ST_PRD) || (state == ST_RD));
  assign ee_we_n     = (state != ST_WLOW);

  // ---------------- assertion-side observers ----------------
  logic          we_prev;
  logic          we_fall;
  logic [TW-1:0] we_low_len;
  logic [GW-1:0] fall_gap;

  assign we_fall = we_prev && !ee_we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_prev    <= 1'b1;
      we_low_len <= '0;
      fall_gap   <= '0;
    end else begin
      we_prev <= ee_we_n;
      if (!ee_we_n) begin
        if (we_low_len != '1) we_low_len <= we_low_len + 1'b1;
      end else begin
        we_low_len <= '0;
      end
      if (we_fall)                          fall_gap <= GW'(1);
      else if (fall_gap != GW'(N_BLC_MAX + 1)) fall_gap <= fall_gap + 1'b1;
    end
  end

  assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_reject_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && reject) |=> (ee_ce_n && done && done_err));

  assert_we_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_we_n && !we_prev) |-> (32'(we_low_len) >= N_WLOW));

  assert_addr_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ee_we_n && !we_prev) |-> ($stable(ee_addr) && $stable(ee_dout)));

  assert_data_after_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_we_n && !we_prev) |-> (ee_dout_en && $stable(ee_dout)));

  assert_oe_off_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ee_we_n || ee_dout_en) |-> (ee_oe_n && !ee_ce_n));

  assert_load_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we_fall && byte_idx != '0) |->
      (32'(fall_gap) >= N_BLC_MIN && 32'(fall_gap) <= N_BLC_MAX));

  assert_timeout_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_timeout) |-> err_timeout);
endmodule

// File: tb/eeprom_page_ctrl_bench.sv
module eeprom_page_ctrl_bench;
  localparam int CLK_HALF  = 5;
  localparam int TMO_NS    = 20000;
  localparam int TMO_CYC   = TMO_NS / 10;
  localparam int WP_CYC    = 15;   // 150 ns at 10 ns
  localparam int AS_CYC    = 2;    // 20 ns
  localparam int GAPMIN    = 20;   // 200 ns
  localparam int GAPMAX    = 200;  // 2000 ns

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_op = '0;
  logic [12:0] req_addr = '0;
  logic [5:0]  req_last = '0;
  logic        req_toggle = 1'b0;
  logic [5:0]  data_idx;
  logic [7:0]  data_byte;
  logic        done, done_err, err_timeout;
  logic [7:0]  rd_data;
  logic [12:0] ee_addr;
  logic [7:0]  ee_dout, ee_din;
  logic        ee_dout_en, ee_ce_n, ee_oe_n, ee_we_n;

  int n_chk = 0;
  int n_bad = 0;

  // device model and host page store
  logic [7:0] dev_mem [0:8191];
  logic [7:0] ref_mem [0:8191];
  logic [7:0] hbuf    [0:63];
  logic [7:0] last_wr = '0;
  logic       tog = 1'b0;
  int         prog_left = 0;
  int         prog_cycles = 300;
  int         cyc = 0;
  bit         ce_seen = 0;
  int         falls_in_req = 0;

  assign data_byte = hbuf[data_idx];
  assign ee_din    = (prog_left > 0) ? {~last_wr[7], tog, last_wr[5:0]} : dev_mem[ee_addr];

  always #(CLK_HALF) clk = ~clk;

  eeprom_page_ctrl #(.POLL_TIMEOUT_NS(TMO_NS)) u_eeprom_page_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_last(req_last), .req_toggle(req_toggle),
    .data_idx(data_idx), .data_byte(data_byte), .done(done), .done_err(done_err),
    .rd_data(rd_data), .err_timeout(err_timeout), .ee_addr(ee_addr), .ee_dout(ee_dout),
    .ee_dout_en(ee_dout_en), .ee_din(ee_din), .ee_ce_n(ee_ce_n), .ee_oe_n(ee_oe_n),
    .ee_we_n(ee_we_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic bit fits(input int off, input int last);
    return (off + last) <= 63;
  endfunction

  // monitor and device model, sampled on the falling clock edge
  logic        prev_we = 1'b1, prev_oe = 1'b1;
  logic [12:0] prev_addr = '0, fall_addr = '0;
  int          addr_age = 0, we_low = 0, since_fall = 0;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 190000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
    if (rst_n) begin
      if (prog_left > 0) prog_left--;
      if (prev_oe && !ee_oe_n && prog_left > 0) tog = ~tog;
      if (!ee_ce_n) ce_seen = 1;
      addr_age = (ee_addr != prev_addr) ? 0 : addr_age + 1;
      if (prev_we && !ee_we_n) begin
        chk(prev_addr == ee_addr && addr_age >= AS_CYC - 1, "R4 addr setup", addr_age, AS_CYC - 1);
        chk(ee_oe_n && !ee_ce_n, "R5 oe high ce low at strobe", {ee_oe_n, ee_ce_n}, 2);
        if (falls_in_req > 0)
          chk(since_fall >= GAPMIN && since_fall <= GAPMAX, "R6 strobe spacing", since_fall, GAPMIN);
        falls_in_req++;
        since_fall = 0;
        fall_addr = ee_addr;
        we_low = 1;
      end else if (!ee_we_n) begin
        we_low++;
        if (ee_addr != fall_addr) chk(0, "R4 addr moved while strobe low", ee_addr, fall_addr);
        if (!ee_oe_n) chk(0, "R5 oe low during strobe", 0, 1);
      end
      if (!prev_we && ee_we_n) begin
        chk(we_low >= WP_CYC, "R4 strobe width", we_low, WP_CYC);
        chk(ee_dout_en, "R4 data driven after rise", ee_dout_en, 1);
        dev_mem[ee_addr] = ee_dout;
        last_wr = ee_dout;
        prog_left = prog_cycles;
      end
      if (ee_dout_en && !ee_oe_n) chk(0, "R5 bus contention", 1, 0);
      since_fall++;
    end
    prev_we = ee_we_n;
    prev_oe = ee_oe_n;
    prev_addr = ee_addr;
  end

  int   t_start;
  logic got_err;
  logic [7:0] got_rd;

  task automatic run_req(input logic [1:0] op, input logic [12:0] addr, input logic [5:0] last,
                         input logic tgl);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    ce_seen = 0;
    falls_in_req = 0;
    req_op = op; req_addr = addr; req_last = last; req_toggle = tgl;
    req_valid = 1'b1;
    t_start = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    got_err = done_err;
    got_rd  = rd_data;
    @(negedge clk);
    chk(!done && req_ready, "R1 done single cycle", done, 0);
  endtask

  task automatic write_req(input logic [1:0] op, input logic [12:0] addr, input logic [5:0] last,
                           input logic tgl, input int prog);
    int n;
    bit rej;
    n = (op == 2'd1) ? 1 : int'(last) + 1;
    rej = (op == 2'd3) || (op == 2'd2 && !fits(int'(addr[5:0]), int'(last)));
    for (int i = 0; i < 64; i++) hbuf[i] = 8'($urandom);
    prog_cycles = prog;
    run_req(op, addr, last, tgl);
    if (rej) begin
      chk(got_err == 1'b1, "R2 reject flagged", got_err, 1);
      chk(!ce_seen, "R2 no bus cycle on reject", ce_seen, 0);
    end else begin
      for (int i = 0; i < n; i++)
        ref_mem[{addr[12:6], 6'(addr[5:0] + 6'(i))}] = hbuf[i];
      if (prog < TMO_CYC - 100) begin
        chk(got_err == 1'b0, tgl ? "R8 toggle poll ok" : "R7 data poll ok", got_err, 0);
        chk(prog_left == 0, tgl ? "R8 done after program end" : "R7 done after program end",
            prog_left, 0);
      end
      for (int i = 0; i < n; i++) begin
        logic [12:0] a;
        a = {addr[12:6], 6'(addr[5:0] + 6'(i))};
        if (dev_mem[a] !== ref_mem[a]) chk(0, "R3 byte stored", dev_mem[a], ref_mem[a]);
      end
      chk(falls_in_req == n, "R3 strobe count", falls_in_req, n);
    end
  endtask

  task automatic read_req(input logic [12:0] addr);
    run_req(2'd0, addr, 6'd0, 1'b0);
    chk(got_err == 1'b0 && got_rd == ref_mem[addr], "R10 read data", got_rd, ref_mem[addr]);
  endtask

  initial begin
    int mism;
    void'($urandom(32'h5EED_1234));
    for (int i = 0; i < 8192; i++) begin dev_mem[i] = '0; ref_mem[i] = '0; end
    for (int i = 0; i < 64; i++) hbuf[i] = '0;
    repeat (3) @(negedge clk);
    chk(ee_ce_n && ee_oe_n && ee_we_n && !ee_dout_en, "R1 bus idle in reset",
        {ee_ce_n, ee_oe_n, ee_we_n, ee_dout_en}, 4'b1110);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready && !err_timeout && !done, "R1 ready after reset", req_ready, 1);

    // directed: single byte, data poll, then read back
    write_req(2'd1, 13'h0123, 6'd0, 1'b0, 300);
    read_req(13'h0123);
    // full page, toggle poll
    write_req(2'd2, 13'h0400, 6'd63, 1'b1, 500);
    read_req(13'h0400);
    read_req(13'h043F);
    // boundary: one over rejects, exact fit accepted
    write_req(2'd2, 13'h0821, 6'd31, 1'b0, 300);
    write_req(2'd2, 13'h0820, 6'd31, 1'b0, 300);
    read_req(13'h083F);
    write_req(2'd3, 13'h0010, 6'd0, 1'b0, 300);
    // timeout: program outlasts the poll limit
    write_req(2'd1, 13'h1F00, 6'd0, 1'b0, TMO_CYC + 3000);
    chk(got_err == 1'b1 && err_timeout, "R9 timeout reported", {got_err, err_timeout}, 3);
    chk(cyc - t_start >= TMO_CYC, "R9 waited full timeout", cyc - t_start, TMO_CYC);
    while (prog_left > 0) @(negedge clk);
    write_req(2'd1, 13'h1F01, 6'd0, 1'b1, 200);
    chk(err_timeout == 1'b1, "R9 flag sticky", err_timeout, 1);
    read_req(13'h1F00);

    // random mix
    for (int k = 0; k < 12; k++) begin
      logic [12:0] a;
      logic [5:0]  l;
      int          sel;
      a = 13'($urandom);
      sel = $urandom % 4;
      if (sel == 0) read_req(a);
      else if (sel == 1) write_req(2'd1, a, 6'd0, 1'($urandom), 100 + $urandom % 700);
      else begin
        l = 6'($urandom);
        if ($urandom % 4 != 0) l = 6'($urandom % (64 - int'(a[5:0])));
        write_req(2'd2, a, l, 1'($urandom), 100 + $urandom % 700);
      end
    end

    mism = 0;
    for (int i = 0; i < 8192; i++) if (dev_mem[i] !== ref_mem[i]) mism++;
    chk(mism == 0, "R3 memory image", mism, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule